// File: doc/BRIEF.md
# Ethernet Multicast Hash Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether it is kept or discarded based on its 48-bit destination address. The address arrives one byte per clock, first byte first, through a valid/ready stream. While the bytes pass, the block runs the Ethernet CRC-32 over them. For a multicast destination, a few bits of the processed CRC select one bin of a hash bitmap, and the bin bit decides the outcome. One clock after the sixth byte, the verdict appears on a decision port with its own valid/ready handshake.

The bitmap holds 64, 128 or 256 bins, chosen at build time through the number of index bits. Software sees the bitmap as a set of 32-bit words next to a control word that holds three mode bits. The first mode accepts everything. The second accepts every multicast frame. The third enables the hash lookup. A read-only capability word reports the table size. A frame uses the configuration that was in place when its first address byte was taken, so reprogramming never corrupts a frame that is already in flight.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash runs over the six address bytes, first byte first and each byte least significant bit first, with the reflected polynomial 0xEDB88320 and an all-ones start value. The bin index is formed by complementing the CRC, bit-reversing it and taking its top HASH_BITS bits. Index bits [HASH_BITS-1:5] select hash word, and bits [4:0] select the bit within that word.
- R2: A frame is multicast when bit 0 of its first address byte is 1. When the hash mode (control bit 2) is set and no other rule accepts the frame, a multicast frame is accepted exactly when its bin bit is 1.
- R3: With no mode bit set, a multicast frame that is not broadcast is dropped.
- R4: Broadcast (all 48 bits one) and non-multicast frames are always accepted, whatever the table holds.
- R5: The promiscuous bit (control bit 0) accepts every frame.
- R6: The pass-all-multicast bit (control bit 4) accepts every multicast frame, even when the table is empty.
- R7: dec_valid rises in the cycle after the sixth address byte is accepted. It is low before that.
- R8: While dec_valid is high and dec_ready is low, dec_valid stays high and dec_accept stays stable. During that time da_ready is low and address bytes are not consumed. The decision retires in the cycle after it is taken.
- R9: The control word at byte offset 0x08 keeps all 32 written bits and reads them back.
- R10: The capability word at offset 0x04 reads HASH_BITS-5 in bits [25:24] and zero elsewhere. Writes to it are ignored.
- R11: Hash word i sits at offset 0x10+4*i for i below 2^(HASH_BITS-5) and reads back what was written. Offsets past the last word read zero.
- R12: Control and table values are sampled when a frame's first byte is accepted. A write during a frame only affects later frames.
- R13: After reset, dec_valid is 0, da_ready is 1, and the control and hash words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Address byte valid |
| da_byte | input | 8 | Destination address byte, first byte first |
| da_ready | output | 1 | Block can take an address byte |
| dec_valid | output | 1 | Decision available |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| dec_ready | input | 1 | Consumer takes the decision |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |

## Verification
The filter is driven with random 48-bit addresses in several classes: multicast, unicast and the occasional broadcast. These run against random bitmap contents and random mode words, which separates a correct CRC-to-bin mapping from a wrong bit order, a wrong word select or a mis-prioritised mode. Directed frames set a single bin and then probe a neighbouring address that hashes elsewhere, which shows that the lookup selects one bit and not a whole word. One frame is reprogrammed in mid-flight, which tells a per-frame snapshot apart from live configuration. A held decision while more address bytes are offered shows that back-pressure really stalls the address stream.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int CTRL_OFS   = 'h08;
   localparam int FEAT_OFS   = 'h04;
   localparam int HASH_BASE  = 'h10;
   localparam int BIT_PROMISC = 0;
   localparam int BIT_HASHMC  = 2;
   localparam int BIT_ALLMC   = 4;
   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

   typedef struct packed {
      logic promisc;
      logic allmc;
      logic hashmc;
   } mode_t;

   function automatic logic [31:0] crc_byte(input logic [31:0] crc_in, input logic [7:0] b);
      logic [31:0] c;
      c = crc_in ^ {24'd0, b};
      for (int k = 0; k < 8; k++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
      return c;
   endfunction
endpackage

// File: rtl/mhf_regs.sv
module mhf_regs
   import mhf_pkg::*;
#(
   parameter int HASH_BITS = 8,
   parameter int ADDR_W    = 8,
   localparam int NREGS    = 2 ** (HASH_BITS - 5),
   localparam int TBL_BITS = NREGS * 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wen,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic [31:0]         ctrl_q,
   output logic [TBL_BITS-1:0] tbl_q
);
   localparam logic [31:0] FEAT_VAL = 32'(HASH_BITS - 5) << 24;

   logic [31:0] words [NREGS];

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (reg_wen && reg_addr == ADDR_W'(CTRL_OFS)) ctrl_q <= reg_wdata;
   end

   for (genvar g = 0; g < NREGS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) words[g] <= '0;
         else if (reg_wen && reg_addr == ADDR_W'(HASH_BASE + 4 * g)) words[g] <= reg_wdata;
      end
      assign tbl_q[g*32 +: 32] = words[g];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_OFS)) reg_rdata = ctrl_q;
      if (reg_addr == ADDR_W'(FEAT_OFS)) reg_rdata = FEAT_VAL;
      for (int i = 0; i < NREGS; i++) begin
         if (reg_addr == ADDR_W'(HASH_BASE + 4 * i)) reg_rdata = words[i];
      end
   end
endmodule

// File: rtl/mhf_addr_path.sv
module mhf_addr_path
   import mhf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        beat,
   input  logic [7:0]  da_byte,
   output logic        first,
   output logic        last,
   output logic [31:0] crc_nx,
   output logic        mc_now,
   output logic        bc_now
);
   logic [2:0]  cnt_q;
   logic [31:0] crc_q;
   logic        mc_q;
   logic        bc_q;

   assign first  = (cnt_q == 3'd0);
   assign last   = (cnt_q == 3'd5);
   assign crc_nx = crc_byte(first ? 32'hFFFF_FFFF : crc_q, da_byte);
   assign mc_now = first ? da_byte[0] : mc_q;
   assign bc_now = (first ? 1'b1 : bc_q) & (&da_byte);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         crc_q <= '1;
         mc_q  <= 1'b0;
         bc_q  <= 1'b0;
      end else if (beat) begin
         cnt_q <= last ? 3'd0 : cnt_q + 3'd1;
         crc_q <= crc_nx;
         mc_q  <= mc_now;
         bc_q  <= bc_now;
      end
   end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
   import mhf_pkg::*;
#(
   parameter int HASH_BITS = 8,
   localparam int TBL_BITS = 32 * 2 ** (HASH_BITS - 5)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                beat,
   input  logic                first,
   input  logic                last,
   input  logic [31:0]         crc_nx,
   input  logic                mc_now,
   input  logic                bc_now,
   input  logic [31:0]         ctrl_q,
   input  logic [TBL_BITS-1:0] tbl_q,
   input  logic                dec_ready,
   output logic                dec_valid,
   output logic                dec_accept
);
   logic [TBL_BITS-1:0]  act_tbl;
   mode_t                act_mode;
   logic [HASH_BITS-1:0] idx;
   logic                 hit;
   logic                 accept_nx;

   always_comb begin
      for (int j = 0; j < HASH_BITS; j++) idx[HASH_BITS-1-j] = ~crc_nx[j];
   end

   assign hit       = act_tbl[idx];
   assign accept_nx = act_mode.promisc | bc_now | ~mc_now | act_mode.allmc
                    | (act_mode.hashmc & hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_tbl  <= '0;
         act_mode <= '0;
      end else if (beat && first) begin
         act_tbl          <= tbl_q;
         act_mode.promisc <= ctrl_q[BIT_PROMISC];
         act_mode.allmc   <= ctrl_q[BIT_ALLMC];
         act_mode.hashmc  <= ctrl_q[BIT_HASHMC];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else if (beat && last) begin
         dec_valid  <= 1'b1;
         dec_accept <= accept_nx;
      end else if (dec_ready) begin
         dec_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int HASH_BITS = 8,
   parameter int ADDR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              da_valid,
   input  logic [7:0]        da_byte,
   output logic              da_ready,
   output logic              dec_valid,
   output logic              dec_accept,
   input  logic              dec_ready,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   localparam int NREGS    = 2 ** (HASH_BITS - 5);
   localparam int TBL_BITS = NREGS * 32;

   if (HASH_BITS < 6 || HASH_BITS > 8) begin : g_bad_bits
      $error("HASH_BITS must be 6, 7 or 8");
   end
   if (HASH_BASE + 4 * NREGS > 2 ** ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the hash words");
   end

   logic                beat, first, last, mc_now, bc_now;
   logic [31:0]         crc_nx, ctrl_q;
   logic [TBL_BITS-1:0] tbl_q;

   assign da_ready = ~dec_valid | dec_ready;
   assign beat     = da_valid & da_ready;

   mhf_regs #(.HASH_BITS(HASH_BITS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q), .tbl_q(tbl_q)
   );

   mhf_addr_path u_path (
      .clk(clk), .rst_n(rst_n), .beat(beat), .da_byte(da_byte), .first(first),
      .last(last), .crc_nx(crc_nx), .mc_now(mc_now), .bc_now(bc_now)
   );

   mhf_decide #(.HASH_BITS(HASH_BITS)) u_dec (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .last(last),
      .crc_nx(crc_nx), .mc_now(mc_now), .bc_now(bc_now), .ctrl_q(ctrl_q),
      .tbl_q(tbl_q), .dec_ready(dec_ready), .dec_valid(dec_valid),
      .dec_accept(dec_accept)
   );
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(
   parameter int HASH_BITS = 8,
   parameter int ADDR_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              da_valid,
   input logic [7:0]        da_byte,
   input logic              da_ready,
   input logic              dec_valid,
   input logic              dec_accept,
   input logic              dec_ready,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata
);
   logic [2:0] seen;
   logic       take;
   assign take = da_valid && da_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else if (take) seen <= (seen == 3'd5) ? 3'd0 : seen + 3'd1;
   end

   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (take && seen == 3'd5) |=> dec_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_accept)));

   a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ready) |-> !da_ready);

   a_r8_retire: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_ready && !(take && seen == 3'd5)) |=> !dec_valid);

   a_r10_feature: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'('h04)) |-> (reg_rdata == (32'(HASH_BITS - 5) << 24)));

   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_valid && !(take && seen == 3'd5)) |=> !dec_valid);
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(.HASH_BITS(HASH_BITS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        da_valid = 0;
   logic [7:0]  da_byte = 0;
   logic        da_ready;
   logic        dec_valid, dec_accept;
   logic        dec_ready = 0;
   logic        reg_wen = 0;
   logic [7:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;

   int total = 0;
   int fails = 0;
   bit done = 0;

   logic [255:0] m_tbl = '0;
   logic [31:0]  m_ctrl = '0;

   always #10 clk = ~clk;

   mcast_hash_filter uut (.*);

   function automatic logic [7:0] exp_idx(input logic [47:0] a);
      logic [31:0] c;
      logic [7:0]  b, r;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         b = a[47-8*i -: 8];
         for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ b[k];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      end
      c = ~c;
      for (int j = 0; j < 8; j++) r[7-j] = c[j];
      return r;
   endfunction

   function automatic logic exp_accept(input logic [47:0] a);
      logic mc, bc;
      mc = a[40];
      bc = &a;
      return m_ctrl[0] | bc | ~mc | m_ctrl[4] | (m_ctrl[2] & m_tbl[exp_idx(a)]);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic void model_wr(input logic [7:0] a, input logic [31:0] d);
      if (a == 8'h08) m_ctrl = d;
      if (a >= 8'h10 && a < 8'h30 && a[1:0] == 2'b00) m_tbl[32'(a - 8'h10) * 8 +: 32] = d;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 0;
      model_wr(a, d);
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp);
   endtask

   task automatic send(input string req, input logic [47:0] a, input bit mid,
                       input logic [7:0] ma, input logic [31:0] md, input bit hold);
      logic e, got;
      e = exp_accept(a);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         da_valid = 1;
         da_byte  = a[47-8*i -: 8];
         reg_wen  = mid && (i == 2);
         reg_addr = ma; reg_wdata = md;
         if (i == 5) chk("R7 early", {31'd0, dec_valid}, 32'd0);
      end
      @(negedge clk);
      da_valid = 0; reg_wen = 0;
      if (mid) model_wr(ma, md);
      chk("R7 valid", {31'd0, dec_valid}, 32'd1);
      got = dec_accept;
      chk(req, {31'd0, got}, {31'd0, e});
      if (hold) begin
         da_valid = 1; da_byte = 8'h5A;
         for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk("R8 held", {30'd0, dec_valid, dec_accept}, {30'd0, 1'b1, got});
            chk("R8 ready", {31'd0, da_ready}, 32'd0);
         end
         da_valid = 0;
      end
      dec_ready = 1;
      @(negedge clk);
      dec_ready = 0;
      chk("R8 retire", {31'd0, dec_valid}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog actual hung expected done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [47:0] a, b;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R13 reset state
      chk("R13 dec_valid", {31'd0, dec_valid}, 32'd0);
      chk("R13 da_ready", {31'd0, da_ready}, 32'd1);
      rdchk("R13 ctrl", 8'h08, 32'd0);
      rdchk("R13 hash0", 8'h10, 32'd0);
      // R10 capability and ignored write
      rdchk("R10 feature", 8'h04, 32'h0300_0000);
      wr(8'h04, 32'hFFFF_FFFF);
      rdchk("R10 feature after write", 8'h04, 32'h0300_0000);
      // R9 control word keeps all bits
      wr(8'h08, 32'hA5A5_0000);
      rdchk("R9 ctrl", 8'h08, 32'hA5A5_0000);
      wr(8'h08, 32'h0);
      // R11 hash words, out of range
      wr(8'h2C, 32'hDEAD_BEEF);
      rdchk("R11 last word", 8'h2C, 32'hDEAD_BEEF);
      rdchk("R11 beyond", 8'h30, 32'h0);
      wr(8'h2C, 32'h0);
      // R3 no mode: multicast dropped; R4 unicast and broadcast kept
      send("R3 mc drop", 48'h0100_5E00_0001, 0, 0, 0, 0);
      send("R4 unicast", 48'h0012_3456_789A, 0, 0, 0, 0);
      wr(8'h08, 32'h4);
      send("R4 broadcast", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 0);
      // R1 R2 single bin
      a = 48'h0100_5E00_0001;
      begin
         logic [7:0] ia;
         ia = exp_idx(a);
         wr(8'h10 + {ia[7:5], 2'b00}, 32'd1 << ia[4:0]);
         send("R1 bin hit", a, 0, 0, 0, 0);
         b = a;
         while (exp_idx(b) == ia) b[7:0] = b[7:0] + 8'd1;
         send("R2 other bin", b, 0, 0, 0, 0);
         wr(8'h10 + {ia[7:5], 2'b00}, 32'd0);
      end
      // R6 pass-all with empty table, R5 promisc
      wr(8'h08, 32'h10);
      send("R6 pass all", 48'h3300_0000_0001, 0, 0, 0, 0);
      wr(8'h08, 32'h1);
      send("R5 promisc", 48'h0100_5E7F_0203, 0, 0, 0, 1);
      // R12 mid-frame write applies to the next frame only
      wr(8'h08, 32'h0);
      send("R12 snapshot old", 48'h0100_5E01_0101, 1, 8'h08, 32'h1, 0);
      send("R12 snapshot new", 48'h0100_5E01_0101, 0, 0, 0, 0);
      // random mix, R1 R2
      for (int n = 0; n < 80; n++) begin
         if (n % 10 == 0) begin
            for (int w = 0; w < 8; w++) wr(8'h10 + 8'(4 * w), $urandom);
            wr(8'h08, ($urandom & 32'hFFFF_FFEA) | (($urandom % 8 == 0) ? 32'h1 : 32'h0)
                      | (($urandom % 6 == 0) ? 32'h10 : 32'h0) | 32'h4);
         end
         a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         if ($urandom % 4 != 0) a[40] = 1'b1;
         if ($urandom % 25 == 0) a = '1;
         send("R2 random", a, 0, 0, 0, (n % 16) == 3);
      end
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule